// File: doc/BRIEF.md
# Header Deparser

This block rebuilds an outgoing packet byte stream at the end of a match-action pipeline. A packet arrives as a descriptor and a raw byte stream. The descriptor carries the Ethernet and IPv4 header contents as they stand after the earlier stages rewrote them, one valid flag for each header, a parse offset, a truncation length and a drop bit. The raw byte stream is the packet as received. The block writes the valid headers from the descriptor and then forwards the original bytes from the parse offset onward. The result leaves on a valid/ready byte stream that marks the first byte and the last byte of each packet.

The descriptor is accepted only between packets. The received header bytes in front of the parse offset are read and thrown away, because their rewritten copies come from the descriptor. A nonzero truncation length limits the number of payload bytes that are sent. The rest of the input packet is still consumed. A dropped packet is consumed in full and sends nothing. Backpressure on the output stalls the header emission and the reading of the payload in the same way.

Top module: `hdr_deparser`

The input packet must hold at least one byte past the parse offset.

## Requirements
- R1: While reset is asserted, and after it is released, the block holds out_valid and in_ready low and desc_ready high.
- R2: When the Ethernet flag is set, the block first emits 14 bytes: the destination address (6 bytes), then the source address (6 bytes), then the type (2 bytes). Each field goes out most significant byte first. The values come from the descriptor, not from the received bytes.
- R3: When the IPv4 flag is set, the block emits the 160-bit IPv4 header vector as 20 bytes, most significant byte first. These bytes follow the Ethernet bytes when Ethernet is present and are the first bytes of the packet when it is not.
- R4: The block emits no byte of a header whose flag is clear. With both flags clear, the packet starts directly with payload.
- R5: The block consumes and discards the first desc_skip input bytes. Every later input byte is emitted unchanged and in order.
- R6: A desc_trunc of zero sends the full payload. A nonzero value N sends at most N payload bytes and sets out_last on the final byte sent. Any input bytes left after that are consumed without output.
- R7: When desc_drop is set, the block emits nothing and consumes input bytes up to and including the one marked in_last. The next packet is then processed normally.
- R8: out_first is high on the first emitted byte of a packet and low on all the others. When no truncation applies, out_last is high on the byte that arrived with in_last.
- R9: While out_ready is low, out_valid and out_data hold their values. Under any pattern of stalls, no byte is lost, duplicated or reordered.
- R10: desc_ready is high only while no packet is in progress, and it drops on the cycle after a descriptor is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Descriptor accepted when high together with desc_valid |
| desc_eth_vld | input | 1 | Ethernet header is to be emitted |
| desc_eth_dst | input | 48 | Ethernet destination address |
| desc_eth_src | input | 48 | Ethernet source address |
| desc_eth_type | input | 16 | Ethernet type field |
| desc_ip_vld | input | 1 | IPv4 header is to be emitted |
| desc_ip_hdr | input | 160 | IPv4 header, byte 0 in the top bits |
| desc_skip | input | OFF_W | Number of received bytes in front of the payload |
| desc_trunc | input | TRUNC_W | Payload byte limit, 0 means no limit |
| desc_drop | input | 1 | Discard the packet |
| in_valid | input | 1 | Received byte available |
| in_ready | output | 1 | Received byte consumed |
| in_data | input | 8 | Received byte |
| in_last | input | 1 | Final received byte of the packet |
| out_valid | output | 1 | Output byte available |
| out_ready | input | 1 | Downstream takes the byte |
| out_data | output | 8 | Output byte |
| out_first | output | 1 | First byte of an output packet |
| out_last | output | 1 | Final byte of an output packet |

## Verification
The hardest case to reach is an output stall that lands on a state boundary. One example is the last header byte held while the skip phase waits. Another is a truncation limit reached while the input still holds bytes, so the following packet depends on a clean drain. The stimulus gets there in two ways. First, it drives out_ready from a pseudo-random sequence while inserting input gaps, for packets that mix header flags, skip offsets and truncation limits of 1, exactly the payload length, and more than the payload length. Second, it places a dropped packet and a truncated packet directly ahead of normal ones, so any residue of unconsumed bytes corrupts the expected stream.

// File: rtl/hdr_deparser_pkg.sv
package hdr_deparser_pkg;
  localparam int ETH_BYTES = 14;
  localparam int IP_BYTES  = 20;
  localparam int HDR_BYTES = ETH_BYTES + IP_BYTES;
  localparam int HDR_W     = HDR_BYTES * 8;
  localparam int IDX_W     = $clog2(HDR_BYTES + 1);

  typedef logic [HDR_W-1:0] hdr_vec_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_SKIP,
    ST_PAY,
    ST_DRAIN
  } dp_state_e;
endpackage

// File: rtl/dp_hdr_emit.sv
module dp_hdr_emit
  import hdr_deparser_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           eth_vld,
  input  logic           ip_vld,
  input  hdr_vec_t       hdr_in,
  input  logic           take,
  output logic [7:0]     byte_out,
  output logic           pending,
  output logic           on_last
);
  hdr_vec_t         hdr_q;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [IDX_W-1:0] end_q, end_d;
  logic             pend_q, pend_d;
  hdr_vec_t         shifted;

  always_comb begin
    idx_d  = idx_q;
    end_d  = end_q;
    pend_d = pend_q;
    if (load) begin
      idx_d  = eth_vld ? '0 : IDX_W'(ETH_BYTES);
      end_d  = ip_vld ? IDX_W'(HDR_BYTES - 1) : IDX_W'(ETH_BYTES - 1);
      pend_d = eth_vld | ip_vld;
    end else if (take && pend_q) begin
      if (idx_q == end_q) pend_d = 1'b0;
      else                idx_d  = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      end_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      idx_q  <= idx_d;
      end_q  <= end_d;
      pend_q <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    hdr_q <= '0;
    else if (load) hdr_q <= hdr_in;
  end

  assign shifted  = hdr_q << {idx_q, 3'b000};
  assign byte_out = shifted[HDR_W-1 -: 8];
  assign pending  = pend_q;
  assign on_last  = pend_q && (idx_q == end_q);

  AST_HDR_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> (idx_q <= end_q)); // R4
  AST_HDR_STEP_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && take && !on_last && !load) |=> (idx_q == $past(idx_q) + 1'b1)); // R3
endmodule

// File: rtl/dp_pay_gate.sv
module dp_pay_gate #(
  parameter int OFF_W   = 8,
  parameter int TRUNC_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [OFF_W-1:0]   skip_len,
  input  logic [TRUNC_W-1:0] trunc_len,
  input  logic               skip_step,
  input  logic               pay_step,
  output logic               need_skip,
  output logic               skip_final,
  output logic               trunc_final
);
  logic [OFF_W-1:0]   skip_q, skip_cnt_q, skip_cnt_d;
  logic [TRUNC_W-1:0] trunc_q, pay_cnt_q, pay_cnt_d;

  always_comb begin
    skip_cnt_d = skip_cnt_q;
    pay_cnt_d  = pay_cnt_q;
    if (load) begin
      skip_cnt_d = '0;
      pay_cnt_d  = '0;
    end else begin
      if (skip_step) skip_cnt_d = skip_cnt_q + 1'b1;
      if (pay_step)  pay_cnt_d  = pay_cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      skip_cnt_q <= '0;
      pay_cnt_q  <= '0;
    end else begin
      skip_cnt_q <= skip_cnt_d;
      pay_cnt_q  <= pay_cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      skip_q  <= '0;
      trunc_q <= '0;
    end else if (load) begin
      skip_q  <= skip_len;
      trunc_q <= trunc_len;
    end
  end

  assign need_skip   = (skip_q != '0);
  assign skip_final  = (skip_cnt_q == skip_q - OFF_W'(1));
  assign trunc_final = (trunc_q != '0) && (pay_cnt_q == trunc_q - TRUNC_W'(1));

  AST_SKIP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    skip_step |-> (skip_cnt_q < skip_q)); // R5
  AST_TRUNC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (pay_step && trunc_q != '0) |-> (pay_cnt_q < trunc_q)); // R6
endmodule

// File: rtl/hdr_deparser.sv
module hdr_deparser
  import hdr_deparser_pkg::*;
#(
  parameter int OFF_W   = 8,
  parameter int TRUNC_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               desc_valid,
  output logic               desc_ready,
  input  logic               desc_eth_vld,
  input  logic [47:0]        desc_eth_dst,
  input  logic [47:0]        desc_eth_src,
  input  logic [15:0]        desc_eth_type,
  input  logic               desc_ip_vld,
  input  logic [159:0]       desc_ip_hdr,
  input  logic [OFF_W-1:0]   desc_skip,
  input  logic [TRUNC_W-1:0] desc_trunc,
  input  logic               desc_drop,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [7:0]         in_data,
  input  logic               in_last,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [7:0]         out_data,
  output logic               out_first,
  output logic               out_last
);
  dp_state_e  state_q, state_d;
  logic       first_q, first_d;
  logic       accept, in_xfer, out_xfer;
  logic [7:0] hdr_byte;
  logic       hdr_pend, hdr_last, hdr_take;
  logic       need_skip, skip_final, trunc_final;
  logic       is_hdr, is_skip, is_pay, is_drain;

  assign is_hdr   = (state_q == ST_HDR);
  assign is_skip  = (state_q == ST_SKIP);
  assign is_pay   = (state_q == ST_PAY);
  assign is_drain = (state_q == ST_DRAIN);

  assign desc_ready = (state_q == ST_IDLE);
  assign accept     = desc_valid && desc_ready;
  assign in_ready   = is_skip || is_drain || (is_pay && out_ready);
  assign in_xfer    = in_valid && in_ready;
  assign out_valid  = (is_hdr && hdr_pend) || (is_pay && in_valid);
  assign out_data   = is_hdr ? hdr_byte : in_data;
  assign out_last   = is_pay && (in_last || trunc_final);
  assign out_first  = first_q;
  assign out_xfer   = out_valid && out_ready;
  assign hdr_take   = is_hdr && out_ready;

  dp_hdr_emit u_hdr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .eth_vld  (desc_eth_vld),
    .ip_vld   (desc_ip_vld),
    .hdr_in   ({desc_eth_dst, desc_eth_src, desc_eth_type, desc_ip_hdr}),
    .take     (hdr_take),
    .byte_out (hdr_byte),
    .pending  (hdr_pend),
    .on_last  (hdr_last)
  );

  dp_pay_gate #(.OFF_W(OFF_W), .TRUNC_W(TRUNC_W)) u_pay (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (accept),
    .skip_len    (desc_skip),
    .trunc_len   (desc_trunc),
    .skip_step   (is_skip && in_xfer),
    .pay_step    (is_pay && in_xfer),
    .need_skip   (need_skip),
    .skip_final  (skip_final),
    .trunc_final (trunc_final)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (accept) begin
        if (desc_drop)                        state_d = ST_DRAIN;
        else if (desc_eth_vld || desc_ip_vld) state_d = ST_HDR;
        else if (desc_skip != '0)             state_d = ST_SKIP;
        else                                  state_d = ST_PAY;
      end
      ST_HDR: if (hdr_take && hdr_last)
        state_d = need_skip ? ST_SKIP : ST_PAY;
      ST_SKIP: if (in_xfer) begin
        if (in_last)         state_d = ST_IDLE;
        else if (skip_final) state_d = ST_PAY;
      end
      ST_PAY: if (in_xfer) begin
        if (in_last)          state_d = ST_IDLE;
        else if (trunc_final) state_d = ST_DRAIN;
      end
      ST_DRAIN: if (in_xfer && in_last) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    first_d = first_q;
    if (accept)        first_d = 1'b1;
    else if (out_xfer) first_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      first_q <= 1'b0;
    end else begin
      state_q <= state_d;
      first_q <= first_d;
    end
  end

  AST_FIRST_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    out_xfer |=> !out_first); // R8
  AST_LAST_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (out_xfer && out_last) |=> !out_valid); // R8
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid); // R9
  AST_STALL_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> $stable(out_data)); // R9
  AST_DESC_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !desc_ready); // R10
endmodule

// File: tb/tb_hdr_deparser.sv
module tb_hdr_deparser;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         desc_valid, desc_ready;
  logic         desc_eth_vld, desc_ip_vld, desc_drop;
  logic [47:0]  desc_eth_dst, desc_eth_src;
  logic [15:0]  desc_eth_type;
  logic [159:0] desc_ip_hdr;
  logic [7:0]   desc_skip;
  logic [15:0]  desc_trunc;
  logic         in_valid, in_ready, in_last;
  logic [7:0]   in_data;
  logic         out_valid, out_ready, out_first, out_last;
  logic [7:0]   out_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;
  bit stall_mode = 0;
  bit gap_mode   = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic [9:0]  exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  hdr_deparser dut (
    .clk(clk), .rst_n(rst_n),
    .desc_valid(desc_valid), .desc_ready(desc_ready),
    .desc_eth_vld(desc_eth_vld), .desc_eth_dst(desc_eth_dst),
    .desc_eth_src(desc_eth_src), .desc_eth_type(desc_eth_type),
    .desc_ip_vld(desc_ip_vld), .desc_ip_hdr(desc_ip_hdr),
    .desc_skip(desc_skip), .desc_trunc(desc_trunc), .desc_drop(desc_drop),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_first(out_first), .out_last(out_last)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] in_byte(input int id, input int i);
    return 8'((id * 37 + i * 11 + 5) & 8'hFF);
  endfunction

  // out_ready driver
  initial begin
    out_ready = 1'b1;
    forever begin
      @(posedge clk); #1;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      out_ready = stall_mode ? lfsr[0] : 1'b1;
    end
  end

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R7", "unexpected output byte", {22'd0, out_first, out_last, out_data}, 32'h0);
        end else begin
          logic [9:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk({out_first, out_last, out_data} == e, t, "byte {first,last,data}",
              {22'd0, out_first, out_last, out_data}, {22'd0, e});
        end
      end
    end
  end

  task automatic send_pkt(input int id, input bit ev, input bit iv, input int skip,
                          input int trunc, input bit drop, input int len);
    logic [47:0]  dst, src;
    logic [15:0]  typ;
    logic [159:0] ip;
    logic [7:0]   hb[$];
    string        ht[$];
    int           npay;
    int           total;
    bit           hs;
    dst = {8'(id), 40'h11_2233_4455};
    src = {8'hC0, 8'(id), 32'h0102_0304};
    typ = 16'h0800 ^ 16'(id);
    for (int k = 0; k < 20; k++) ip[159 - 8*k -: 8] = 8'((k * 13 + id) & 8'hFF);
    if (ev) begin
      for (int k = 0; k < 6; k++) begin hb.push_back(dst[47 - 8*k -: 8]); ht.push_back("R2"); end
      for (int k = 0; k < 6; k++) begin hb.push_back(src[47 - 8*k -: 8]); ht.push_back("R2"); end
      for (int k = 0; k < 2; k++) begin hb.push_back(typ[15 - 8*k -: 8]); ht.push_back("R2"); end
    end
    if (iv) begin
      for (int k = 0; k < 20; k++) begin hb.push_back(ip[159 - 8*k -: 8]); ht.push_back("R3"); end
    end
    npay = len - skip;
    if (trunc != 0 && trunc < npay) npay = trunc;
    total = hb.size() + npay;
    if (!drop) begin
      for (int k = 0; k < total; k++) begin
        logic [7:0] d;
        string t;
        if (k < hb.size()) begin d = hb[k]; t = ht[k]; end
        else begin
          d = in_byte(id, skip + k - hb.size());
          t = (trunc != 0) ? "R6" : ((ev || iv) ? "R5" : "R4");
        end
        exp_q.push_back({(k == 0), (k == total - 1), d});
        tag_q.push_back(t);
      end
    end
    desc_valid = 1'b1; desc_eth_vld = ev; desc_ip_vld = iv; desc_drop = drop;
    desc_eth_dst = dst; desc_eth_src = src; desc_eth_type = typ; desc_ip_hdr = ip;
    desc_skip = 8'(skip); desc_trunc = 16'(trunc);
    do begin
      @(negedge clk); hs = desc_valid && desc_ready;
      @(posedge clk); #1;
    end while (!hs);
    desc_valid = 1'b0;
    @(negedge clk);
    chk(desc_ready == 1'b0, "R10", "desc_ready during packet", {31'd0, desc_ready}, 32'h0);
    @(posedge clk); #1;
    for (int i = 0; i < len; i++) begin
      if (gap_mode && (i % 3 == 1)) begin in_valid = 1'b0; @(posedge clk); #1; end
      in_valid = 1'b1; in_data = in_byte(id, i); in_last = (i == len - 1);
      do begin
        @(negedge clk); hs = in_valid && in_ready;
        @(posedge clk); #1;
      end while (!hs);
    end
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    desc_valid = 0; desc_eth_vld = 0; desc_ip_vld = 0; desc_drop = 0;
    desc_eth_dst = '0; desc_eth_src = '0; desc_eth_type = '0; desc_ip_hdr = '0;
    desc_skip = '0; desc_trunc = '0; in_valid = 0; in_data = '0; in_last = 0;
    repeat (3) @(negedge clk);
    chk(out_valid == 0, "R1", "out_valid in reset", {31'd0, out_valid}, 32'h0);
    chk(in_ready == 0, "R1", "in_ready in reset", {31'd0, in_ready}, 32'h0);
    chk(desc_ready == 1, "R1", "desc_ready in reset", {31'd0, desc_ready}, 32'h1);
    @(posedge clk); #1; rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 0 && in_ready == 0 && desc_ready == 1, "R1", "idle after reset",
        {29'd0, out_valid, in_ready, desc_ready}, 32'h1);
    @(posedge clk); #1;

    send_pkt(1, 1, 1, 34, 0,   0, 50);  // R2 R3 R5 R8
    send_pkt(2, 1, 0, 14, 0,   0, 20);  // R4 eth only
    send_pkt(3, 0, 1, 20, 0,   0, 30);  // R4 ip only
    send_pkt(4, 0, 0, 0,  0,   0, 10);  // R4 R5 no headers
    send_pkt(5, 1, 1, 34, 5,   0, 60);  // R6 truncate
    send_pkt(6, 1, 1, 34, 0,   1, 40);  // R7 drop
    send_pkt(7, 1, 0, 3,  1,   0, 20);  // R6 limit of one
    send_pkt(8, 0, 0, 4,  6,   0, 10);  // R6 limit equals payload
    send_pkt(9, 0, 1, 2,  100, 0, 12);  // R6 limit above payload
    stall_mode = 1; gap_mode = 1;
    send_pkt(10, 1, 1, 34, 0, 0, 64);   // R9 stalls
    send_pkt(11, 0, 0, 5,  0, 1, 25);   // R7 drop under stalls
    send_pkt(12, 1, 0, 14, 7, 0, 40);   // R9 R6 truncation under stalls
    send_pkt(13, 0, 1, 0,  0, 0, 9);    // R9 skip zero with header
    for (int w = 0; w < 2000 && exp_q.size() != 0; w++) @(posedge clk);
    stall_mode = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(exp_q.size() == 0, "R9", "bytes still expected", exp_q.size(), 32'h0);
    chk(out_valid == 0 && desc_ready == 1, "R8", "idle after final packet",
        {30'd0, out_valid, desc_ready}, 32'h1);
    done = 1;
    summary();
    $finish;
  end
endmodule